// File: doc/BRIEF.md
# Arcade CPU Bus Glue Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the peripherals on a small arcade board. It watches each bus cycle and turns the address into chip selects and write strobes for a video controller, a local register RAM, two sample-playback sound devices and a math/protection device. It also multiplexes read data from the player input ports, the DIP switch banks and the devices back onto the CPU data bus. The peripherals, the ROMs and the CPU itself sit outside the block.

Two small pieces of state live inside. The first is a bank register loaded by a CPU write. It pages one of four 16 KB program-ROM pages into the CPU window at 0x4000-0x7FFF, picks the sample-ROM bank of the second sound device, and drives two coin-counter outputs. The second is a frame-counting watchdog. The CPU must kick it by writing a fixed address, or it raises a reset request.

Top module: `arcbus_glue`

## Requirements
- R1: A write to any address 0x0000-0x0007 pulses `vid_ctrl_we` in that cycle, with `vid_ctrl_idx` equal to address bits [2:0]. Other writes and all reads leave `vid_ctrl_we` low.
- R2: A write to any address below 0x0060 pulses `regram_we`, with `regram_addr` equal to address bits [6:0]. Addresses 0x0000-0x0007 therefore raise both `vid_ctrl_we` and `regram_we`, while a write to 0x0060 raises neither.
- R3: A read or write in 0x0D00-0x0D0F asserts `snd0_cs`, and one in 0x0E00-0x0E0F asserts `snd1_cs`. In both windows `snd_reg` equals address bits [3:0] with bit 0 inverted. 0x0D10 selects no device.
- R4: A read or write in 0x0F00-0x0F1F asserts `math_cs`, with `math_reg` equal to address bits [4:0]. 0x0F20 is outside the window.
- R5: Only a write to exactly 0x0B00 pulses `wdog_kick`, for the one cycle of that write. A read of 0x0B00 and writes to 0x0B01 or 0x0C00 give no kick.
- R6: Reset clears the bank register. A write to 0x0C00 loads it at the next clock edge. Bits [1:0] drive `coin_ctr` and bit 4 drives `samp_bank`. The register keeps its value through all other cycles.
- R7: A read in 0x4000-0x7FFF asserts `rom_win_sel`. `rom_addr` is 0x10000 + page*0x4000 + address[13:0], where page is bank register bits [3:2].
- R8: Reads return `dip_c` at 0x0800, `in_p2` at 0x0801, `in_p1` at 0x0802, `in_p0` at 0x0803, `dip_a` at 0x0900 and `dip_b` at 0x0901. Reads in the sound and math windows return the selected device's read data. Port bytes pass unchanged: they are active-low, so an idle port reads 0xFF.
- R9: A read of an unmapped address, for example 0x0804, 0x0902 or 0x0B00, returns 0x00. `cpu_rdata` is 0x00 whenever `cpu_rd` is low.
- R10: The watchdog counts `frame_tick` pulses. Once WDOG_FRAMES pulses arrive with no kick between them, `wdog_reset_req` goes high for one cycle after the last of them, and the count restarts. A kick clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, zero when not reading |
| vid_ctrl_we | output | 1 | Video controller register write |
| vid_ctrl_idx | output | 3 | Video controller register index |
| regram_we | output | 1 | Local register RAM write |
| regram_addr | output | 7 | Local register RAM address |
| snd0_cs | output | 1 | Sound device 0 select |
| snd1_cs | output | 1 | Sound device 1 select |
| snd_reg | output | 4 | Sound device register index (LSB swapped) |
| snd0_rdata | input | 8 | Sound device 0 read data |
| snd1_rdata | input | 8 | Sound device 1 read data |
| math_cs | output | 1 | Math/protection device select |
| math_reg | output | 5 | Math device register index |
| math_rdata | input | 8 | Math device read data |
| in_p0 | input | 8 | Input port 0 (active low) |
| in_p1 | input | 8 | Input port 1 (active low) |
| in_p2 | input | 8 | Input port 2 (active low) |
| dip_a | input | 8 | DIP bank A |
| dip_b | input | 8 | DIP bank B |
| dip_c | input | 8 | DIP bank C |
| wdog_kick | output | 1 | Watchdog kick pulse |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| wdog_reset_req | output | 1 | Watchdog expiry pulse |
| rom_win_sel | output | 1 | Banked ROM window read |
| rom_addr | output | 17 | Program ROM address in the banked window |
| samp_bank | output | 1 | Sample ROM bank of sound device 1 |
| coin_ctr | output | 2 | Coin counter drives |

## Verification
The bench builds the block with WDOG_FRAMES set to 5 and leaves every other parameter at its default. With 5 frames, expiry, a kick partway through a count, and the single-cycle request pulse can all be reached in a few dozen cycles instead of 180 frames. The default sound-index variant stays in place, so the bench observes the inverted register-index bit at the ports. The default ROM geometry lets it check the top page, where the computed ROM address reaches 0x1FFFF.

// File: rtl/arcbus_pkg.sv
package arcbus_pkg;

   localparam int unsigned CPU_AW = 16;

   // fixed memory map of the board
   localparam logic [CPU_AW-1:0] MAP_VID_BASE  = 16'h0000;
   localparam int unsigned       MAP_VID_LSB   = 3;
   localparam logic [CPU_AW-1:0] MAP_SND0_BASE = 16'h0D00;
   localparam logic [CPU_AW-1:0] MAP_SND1_BASE = 16'h0E00;
   localparam int unsigned       MAP_SND_LSB   = 4;
   localparam logic [CPU_AW-1:0] MAP_MATH_BASE = 16'h0F00;
   localparam int unsigned       MAP_MATH_LSB  = 5;
   localparam logic [CPU_AW-1:0] MAP_KICK      = 16'h0B00;
   localparam logic [CPU_AW-1:0] MAP_BANK      = 16'h0C00;
   localparam logic [CPU_AW-1:0] MAP_DIP_C     = 16'h0800;
   localparam logic [CPU_AW-1:0] MAP_IN_2      = 16'h0801;
   localparam logic [CPU_AW-1:0] MAP_IN_1      = 16'h0802;
   localparam logic [CPU_AW-1:0] MAP_IN_0      = 16'h0803;
   localparam logic [CPU_AW-1:0] MAP_DIP_A     = 16'h0900;
   localparam logic [CPU_AW-1:0] MAP_DIP_B     = 16'h0901;

   typedef struct packed {
      logic vid_ctrl;
      logic regram;
      logic snd0;
      logic snd1;
      logic math;
      logic kick;
      logic bank;
   } wsel_t;

   typedef struct packed {
      logic dip_c;
      logic in2;
      logic in1;
      logic in0;
      logic dip_a;
      logic dip_b;
      logic snd0;
      logic snd1;
      logic math;
   } rsel_t;

   function automatic logic in_block(input logic [CPU_AW-1:0] a,
                                     input logic [CPU_AW-1:0] base,
                                     input int unsigned lsb);
      return (a >> lsb) == (base >> lsb);
   endfunction

endpackage

// File: rtl/arcbus_addr_decode.sv
module arcbus_addr_decode
   import arcbus_pkg::*;
#(
   parameter int unsigned REGRAM_LIMIT = 'h60,
   parameter int unsigned REGRAM_AW    = 7,
   parameter bit          SND_LSB_SWAP = 1'b1
) (
   input  logic [CPU_AW-1:0]    addr,
   input  logic                 wr,
   input  logic                 rd,
   output wsel_t                wsel,
   output rsel_t                rsel,
   output logic [2:0]           vid_idx,
   output logic [REGRAM_AW-1:0] ram_addr,
   output logic [3:0]           snd_reg,
   output logic [4:0]           math_reg
);

   generate
      if ((1 << REGRAM_AW) < REGRAM_LIMIT) begin : g_bad_ram
         $error("REGRAM_AW too small for REGRAM_LIMIT");
      end
      if (REGRAM_LIMIT < (1 << MAP_VID_LSB)) begin : g_bad_limit
         $error("register RAM must cover the video control block");
      end
   endgenerate

   logic hit_snd0, hit_snd1, hit_math;

   assign hit_snd0 = in_block(addr, MAP_SND0_BASE, MAP_SND_LSB);
   assign hit_snd1 = in_block(addr, MAP_SND1_BASE, MAP_SND_LSB);
   assign hit_math = in_block(addr, MAP_MATH_BASE, MAP_MATH_LSB);

   always_comb begin
      wsel          = '0;
      wsel.vid_ctrl = wr && in_block(addr, MAP_VID_BASE, MAP_VID_LSB);
      wsel.regram   = wr && (32'(addr) < REGRAM_LIMIT);
      wsel.snd0     = wr && hit_snd0;
      wsel.snd1     = wr && hit_snd1;
      wsel.math     = wr && hit_math;
      wsel.kick     = wr && (addr == MAP_KICK);
      wsel.bank     = wr && (addr == MAP_BANK);
   end

   always_comb begin
      rsel       = '0;
      rsel.dip_c = rd && (addr == MAP_DIP_C);
      rsel.in2   = rd && (addr == MAP_IN_2);
      rsel.in1   = rd && (addr == MAP_IN_1);
      rsel.in0   = rd && (addr == MAP_IN_0);
      rsel.dip_a = rd && (addr == MAP_DIP_A);
      rsel.dip_b = rd && (addr == MAP_DIP_B);
      rsel.snd0  = rd && hit_snd0;
      rsel.snd1  = rd && hit_snd1;
      rsel.math  = rd && hit_math;
   end

   assign vid_idx  = addr[2:0];
   assign ram_addr = addr[REGRAM_AW-1:0];
   assign math_reg = addr[4:0];

   generate
      if (SND_LSB_SWAP) begin : g_snd_swap
         assign snd_reg = {addr[3:1], ~addr[0]};
      end else begin : g_snd_straight
         assign snd_reg = addr[3:0];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({addr, wr, rd})) begin
         AST_VID_ALSO_RAM: assert (!wsel.vid_ctrl || wsel.regram); // R2
         AST_RSEL_ONEHOT: assert ($onehot0(rsel)); // R8
      end
   end

endmodule

// File: rtl/arcbus_bank_reg.sv
module arcbus_bank_reg
   import arcbus_pkg::*;
#(
   parameter int unsigned PAGE_AW  = 14,
   parameter int unsigned ROM_AW   = 17,
   parameter int unsigned ROM_BASE = 'h10000,
   parameter int unsigned WIN_BASE = 'h4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [4:0]        wdata,
   input  logic [CPU_AW-1:0] addr,
   input  logic              rd,
   output logic [1:0]        coin_ctr,
   output logic              samp_bank,
   output logic              win_sel,
   output logic [ROM_AW-1:0] rom_addr
);

   localparam int unsigned PAGE_SEL_W = 2;
   localparam int unsigned NUM_PAGES  = 1 << PAGE_SEL_W;
   localparam int unsigned PAGE_BYTES = 1 << PAGE_AW;
   localparam int unsigned BANK_W     = 5;

   generate
      if (ROM_BASE + NUM_PAGES * PAGE_BYTES > (1 << ROM_AW)) begin : g_bad_rom
         $error("banked pages do not fit in ROM_AW");
      end
      if (PAGE_AW >= CPU_AW) begin : g_bad_page
         $error("page larger than CPU space");
      end
      if ((WIN_BASE % PAGE_BYTES) != 0) begin : g_bad_win
         $error("window base must be page aligned");
      end
   endgenerate

   logic [BANK_W-1:0]     bank_q;
   logic [PAGE_SEL_W-1:0] page;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (load) begin
         bank_q <= wdata;
      end
   end

   assign coin_ctr  = bank_q[1:0];
   assign page      = bank_q[3:2];
   assign samp_bank = bank_q[4];

   assign win_sel  = rd && ((addr >> PAGE_AW) == CPU_AW'(WIN_BASE >> PAGE_AW));
   assign rom_addr = ROM_AW'(ROM_BASE)
                   + (ROM_AW'(page) << PAGE_AW)
                   + ROM_AW'(addr[PAGE_AW-1:0]);

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(bank_q)); // R6
   AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> bank_q == $past(wdata)); // R6

endmodule

// File: rtl/arcbus_watchdog.sv
module arcbus_watchdog #(
   parameter int unsigned WDOG_FRAMES = 180
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   input  logic tick,
   output logic req
);

   localparam int unsigned CNT_W = $clog2(WDOG_FRAMES + 1);

   generate
      if (WDOG_FRAMES < 2) begin : g_bad_frames
         $error("WDOG_FRAMES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         req <= 1'b0;
      end else begin
         req <= 1'b0;
         if (kick) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt == CNT_W'(WDOG_FRAMES - 1)) begin
               cnt <= '0;
               req <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req); // R10
   AST_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !req); // R10
   AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !req); // R10

endmodule

// File: rtl/arcbus_read_mux.sv
module arcbus_read_mux
   import arcbus_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  rsel_t             rsel,
   input  logic [DATA_W-1:0] dip_a,
   input  logic [DATA_W-1:0] dip_b,
   input  logic [DATA_W-1:0] dip_c,
   input  logic [DATA_W-1:0] in_p0,
   input  logic [DATA_W-1:0] in_p1,
   input  logic [DATA_W-1:0] in_p2,
   input  logic [DATA_W-1:0] snd0_rdata,
   input  logic [DATA_W-1:0] snd1_rdata,
   input  logic [DATA_W-1:0] math_rdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned NSRC = $bits(rsel_t);

   logic [NSRC-1:0]   sel_vec;
   logic [DATA_W-1:0] src [NSRC];

   assign sel_vec = rsel;

   // order follows the packed struct, MSB first
   assign src[8] = dip_c;
   assign src[7] = in_p2;
   assign src[6] = in_p1;
   assign src[5] = in_p0;
   assign src[4] = dip_a;
   assign src[3] = dip_b;
   assign src[2] = snd0_rdata;
   assign src[1] = snd1_rdata;
   assign src[0] = math_rdata;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NSRC; i++) begin
         rdata = rdata | (src[i] & {DATA_W{sel_vec[i]}});
      end
   end

endmodule

// File: rtl/arcbus_glue.sv
module arcbus_glue
   import arcbus_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned REGRAM_LIMIT = 'h60,
   parameter int unsigned REGRAM_AW    = 7,
   parameter bit          SND_LSB_SWAP = 1'b1,
   parameter int unsigned PAGE_AW      = 14,
   parameter int unsigned ROM_AW       = 17,
   parameter int unsigned ROM_BASE     = 'h10000,
   parameter int unsigned WIN_BASE     = 'h4000,
   parameter int unsigned WDOG_FRAMES  = 180
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          cpu_addr,
   input  logic                 cpu_wr,
   input  logic                 cpu_rd,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic [DATA_W-1:0]    cpu_rdata,
   output logic                 vid_ctrl_we,
   output logic [2:0]           vid_ctrl_idx,
   output logic                 regram_we,
   output logic [REGRAM_AW-1:0] regram_addr,
   output logic                 snd0_cs,
   output logic                 snd1_cs,
   output logic [3:0]           snd_reg,
   input  logic [DATA_W-1:0]    snd0_rdata,
   input  logic [DATA_W-1:0]    snd1_rdata,
   output logic                 math_cs,
   output logic [4:0]           math_reg,
   input  logic [DATA_W-1:0]    math_rdata,
   input  logic [DATA_W-1:0]    in_p0,
   input  logic [DATA_W-1:0]    in_p1,
   input  logic [DATA_W-1:0]    in_p2,
   input  logic [DATA_W-1:0]    dip_a,
   input  logic [DATA_W-1:0]    dip_b,
   input  logic [DATA_W-1:0]    dip_c,
   output logic                 wdog_kick,
   input  logic                 frame_tick,
   output logic                 wdog_reset_req,
   output logic                 rom_win_sel,
   output logic [ROM_AW-1:0]    rom_addr,
   output logic                 samp_bank,
   output logic [1:0]           coin_ctr
);

   generate
      if (DATA_W < 5) begin : g_bad_data
         $error("DATA_W must hold the five bank register bits");
      end
   endgenerate

   wsel_t wsel;
   rsel_t rsel;

   arcbus_addr_decode #(
      .REGRAM_LIMIT (REGRAM_LIMIT),
      .REGRAM_AW    (REGRAM_AW),
      .SND_LSB_SWAP (SND_LSB_SWAP)
   ) u_decode (
      .addr     (cpu_addr),
      .wr       (cpu_wr),
      .rd       (cpu_rd),
      .wsel     (wsel),
      .rsel     (rsel),
      .vid_idx  (vid_ctrl_idx),
      .ram_addr (regram_addr),
      .snd_reg  (snd_reg),
      .math_reg (math_reg)
   );

   assign vid_ctrl_we = wsel.vid_ctrl;
   assign regram_we   = wsel.regram;
   assign snd0_cs     = wsel.snd0 | rsel.snd0;
   assign snd1_cs     = wsel.snd1 | rsel.snd1;
   assign math_cs     = wsel.math | rsel.math;
   assign wdog_kick   = wsel.kick;

   arcbus_bank_reg #(
      .PAGE_AW  (PAGE_AW),
      .ROM_AW   (ROM_AW),
      .ROM_BASE (ROM_BASE),
      .WIN_BASE (WIN_BASE)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wsel.bank),
      .wdata     (cpu_wdata[4:0]),
      .addr      (cpu_addr),
      .rd        (cpu_rd),
      .coin_ctr  (coin_ctr),
      .samp_bank (samp_bank),
      .win_sel   (rom_win_sel),
      .rom_addr  (rom_addr)
   );

   arcbus_watchdog #(
      .WDOG_FRAMES (WDOG_FRAMES)
   ) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (wsel.kick),
      .tick  (frame_tick),
      .req   (wdog_reset_req)
   );

   arcbus_read_mux #(
      .DATA_W (DATA_W)
   ) u_rmux (
      .rsel       (rsel),
      .dip_a      (dip_a),
      .dip_b      (dip_b),
      .dip_c      (dip_c),
      .in_p0      (in_p0),
      .in_p1      (in_p1),
      .in_p2      (in_p2),
      .snd0_rdata (snd0_rdata),
      .snd1_rdata (snd1_rdata),
      .math_rdata (math_rdata),
      .rdata      (cpu_rdata)
   );

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> cpu_rdata == '0); // R9
   AST_KICK_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |-> !wdog_kick && !vid_ctrl_we && !regram_we); // R5

endmodule

// File: tb/arcbus_glue_tb.sv
module arcbus_glue_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cpu_addr;
   logic        cpu_wr, cpu_rd;
   logic [7:0]  cpu_wdata, cpu_rdata;
   logic        vid_ctrl_we;
   logic [2:0]  vid_ctrl_idx;
   logic        regram_we;
   logic [6:0]  regram_addr;
   logic        snd0_cs, snd1_cs;
   logic [3:0]  snd_reg;
   logic [7:0]  snd0_rdata, snd1_rdata;
   logic        math_cs;
   logic [4:0]  math_reg;
   logic [7:0]  math_rdata;
   logic [7:0]  in_p0, in_p1, in_p2, dip_a, dip_b, dip_c;
   logic        wdog_kick, frame_tick, wdog_reset_req;
   logic        rom_win_sel;
   logic [16:0] rom_addr;
   logic        samp_bank;
   logic [1:0]  coin_ctr;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arcbus_glue #(.WDOG_FRAMES(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .vid_ctrl_we(vid_ctrl_we), .vid_ctrl_idx(vid_ctrl_idx),
      .regram_we(regram_we), .regram_addr(regram_addr),
      .snd0_cs(snd0_cs), .snd1_cs(snd1_cs), .snd_reg(snd_reg),
      .snd0_rdata(snd0_rdata), .snd1_rdata(snd1_rdata),
      .math_cs(math_cs), .math_reg(math_reg), .math_rdata(math_rdata),
      .in_p0(in_p0), .in_p1(in_p1), .in_p2(in_p2),
      .dip_a(dip_a), .dip_b(dip_b), .dip_c(dip_c),
      .wdog_kick(wdog_kick), .frame_tick(frame_tick),
      .wdog_reset_req(wdog_reset_req), .rom_win_sel(rom_win_sel),
      .rom_addr(rom_addr), .samp_bank(samp_bank), .coin_ctr(coin_ctr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wr = w; cpu_rd = r; cpu_wdata = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      cpu_addr = 16'hFFFF; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = 8'h00;
      #1;
   endtask

   task automatic tick();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      #1;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_reset();
      apply_reset();
      chk("R6 reset coin", 32'(coin_ctr), 0);
      chk("R6 reset samp", 32'(samp_bank), 0);
      chk("R10 reset req", 32'(wdog_reset_req), 0);
      chk("R9 idle rdata", 32'(cpu_rdata), 0);
   endtask

   task automatic t_vid_regram();
      bus(16'h0007, 1, 0, 8'h11);
      chk("R1 vid we 0x0007", 32'(vid_ctrl_we), 1);
      chk("R1 vid idx", 32'(vid_ctrl_idx), 7);
      chk("R2 ram we overlap", 32'(regram_we), 1);
      bus(16'h0008, 1, 0, 8'h22);
      chk("R1 vid we 0x0008", 32'(vid_ctrl_we), 0);
      chk("R2 ram we 0x0008", 32'(regram_we), 1);
      bus(16'h005F, 1, 0, 8'h33);
      chk("R2 ram we 0x005F", 32'(regram_we), 1);
      chk("R2 ram addr", 32'(regram_addr), 32'h5F);
      bus(16'h0060, 1, 0, 8'h44);
      chk("R2 ram we 0x0060", 32'(regram_we), 0);
      bus(16'h0003, 0, 1, 8'h00);
      chk("R1 read no vid we", 32'(vid_ctrl_we), 0);
      idle();
   endtask

   task automatic t_sound();
      bus(16'h0D05, 1, 0, 8'h5A);
      chk("R3 snd0 cs", 32'(snd0_cs), 1);
      chk("R3 snd1 cs", 32'(snd1_cs), 0);
      chk("R3 snd reg swap", 32'(snd_reg), 4);
      bus(16'h0E02, 0, 1, 8'h00);
      chk("R3 snd1 cs read", 32'(snd1_cs), 1);
      chk("R3 snd reg swap read", 32'(snd_reg), 3);
      chk("R8 snd1 rdata", 32'(cpu_rdata), 32'h6D);
      bus(16'h0D0F, 0, 1, 8'h00);
      chk("R8 snd0 rdata", 32'(cpu_rdata), 32'h4C);
      chk("R3 snd reg 0xF", 32'(snd_reg), 32'hE);
      bus(16'h0D10, 0, 1, 8'h00);
      chk("R3 0x0D10 no cs", 32'({snd0_cs, snd1_cs}), 0);
      chk("R9 0x0D10 reads zero", 32'(cpu_rdata), 0);
      idle();
   endtask

   task automatic t_math();
      bus(16'h0F1F, 0, 1, 8'h00);
      chk("R4 math cs", 32'(math_cs), 1);
      chk("R4 math reg", 32'(math_reg), 32'h1F);
      chk("R8 math rdata", 32'(cpu_rdata), 32'h96);
      bus(16'h0F00, 1, 0, 8'h01);
      chk("R4 math cs write", 32'(math_cs), 1);
      bus(16'h0F20, 0, 1, 8'h00);
      chk("R4 0x0F20 no cs", 32'(math_cs), 0);
      chk("R9 0x0F20 zero", 32'(cpu_rdata), 0);
      idle();
   endtask

   task automatic t_kick();
      bus(16'h0B00, 1, 0, 8'h00);
      chk("R5 kick on write", 32'(wdog_kick), 1);
      idle();
      chk("R5 kick one cycle", 32'(wdog_kick), 0);
      bus(16'h0B00, 0, 1, 8'h00);
      chk("R5 read no kick", 32'(wdog_kick), 0);
      chk("R9 0x0B00 reads zero", 32'(cpu_rdata), 0);
      bus(16'h0B01, 1, 0, 8'h00);
      chk("R5 0x0B01 no kick", 32'(wdog_kick), 0);
      idle();
   endtask

   task automatic t_bank();
      bus(16'h0C00, 1, 0, 8'h1B);
      chk("R6 no change before edge", 32'(coin_ctr), 0);
      chk("R5 bank write no kick", 32'(wdog_kick), 0);
      idle();
      chk("R6 coin", 32'(coin_ctr), 3);
      chk("R6 samp", 32'(samp_bank), 1);
      bus(16'h0C01, 1, 0, 8'h00);
      idle();
      chk("R6 hold on other write", 32'({samp_bank, coin_ctr}), 32'h7);
      bus(16'h5123, 0, 1, 8'h00);
      chk("R7 window sel", 32'(rom_win_sel), 1);
      chk("R7 rom addr page 2", 32'(rom_addr), 32'h19123);
      bus(16'h0C00, 1, 0, 8'h0C);
      idle();
      chk("R6 reload coin", 32'(coin_ctr), 0);
      chk("R6 reload samp", 32'(samp_bank), 0);
      bus(16'h7FFF, 0, 1, 8'h00);
      chk("R7 rom addr top", 32'(rom_addr), 32'h1FFFF);
      bus(16'h4000, 0, 1, 8'h00);
      chk("R7 rom addr base page 3", 32'(rom_addr), 32'h1C000);
      bus(16'h8000, 0, 1, 8'h00);
      chk("R7 0x8000 outside", 32'(rom_win_sel), 0);
      bus(16'h3FFF, 0, 1, 8'h00);
      chk("R7 0x3FFF outside", 32'(rom_win_sel), 0);
      idle();
   endtask

   task automatic t_ports();
      bus(16'h0800, 0, 1, 8'h00); chk("R8 dip c", 32'(cpu_rdata), 32'h3C);
      bus(16'h0801, 0, 1, 8'h00); chk("R8 in2",  32'(cpu_rdata), 32'h7F);
      bus(16'h0802, 0, 1, 8'h00); chk("R8 in1 idle", 32'(cpu_rdata), 32'hFF);
      bus(16'h0803, 0, 1, 8'h00); chk("R8 in0",  32'(cpu_rdata), 32'hFE);
      bus(16'h0900, 0, 1, 8'h00); chk("R8 dip a", 32'(cpu_rdata), 32'h5A);
      bus(16'h0901, 0, 1, 8'h00); chk("R8 dip b", 32'(cpu_rdata), 32'hA5);
      bus(16'h0804, 0, 1, 8'h00); chk("R9 0x0804 zero", 32'(cpu_rdata), 0);
      bus(16'h0902, 0, 1, 8'h00); chk("R9 0x0902 zero", 32'(cpu_rdata), 0);
      bus(16'h0800, 1, 0, 8'h77); chk("R9 no read zero", 32'(cpu_rdata), 0);
      idle();
   endtask

   task automatic t_watchdog();
      apply_reset();
      repeat (4) tick();
      chk("R10 no req after 4", 32'(wdog_reset_req), 0);
      tick();
      chk("R10 req after 5", 32'(wdog_reset_req), 1);
      idle();
      chk("R10 req one cycle", 32'(wdog_reset_req), 0);
      repeat (4) tick();
      bus(16'h0B00, 1, 0, 8'h00);
      idle();
      repeat (4) tick();
      chk("R10 kick restarts count", 32'(wdog_reset_req), 0);
      tick();
      chk("R10 req after kick+5", 32'(wdog_reset_req), 1);
      idle();
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0;
      cpu_addr = 16'hFFFF; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = 8'h00;
      frame_tick = 1'b0;
      snd0_rdata = 8'h4C; snd1_rdata = 8'h6D; math_rdata = 8'h96;
      in_p0 = 8'hFE; in_p1 = 8'hFF; in_p2 = 8'h7F;
      dip_a = 8'h5A; dip_b = 8'hA5; dip_c = 8'h3C;
      t_reset();
      t_vid_regram();
      t_sound();
      t_math();
      t_kick();
      t_bank();
      t_ports();
      t_watchdog();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_tests++;
      n_fail++;
      $display("FAIL TIMEOUT actual=running expected=done");
      finish_run();
   end

endmodule